// File: doc/BRIEF.md
# Codec Register Access Slot Controller

This block lets a host read and write the control registers of an audio codec through the command and data slots of an audio link frame. The host loads the slot-2 transmit word first and then writes the slot-1 command word. The slot-1 write starts one codec transaction. The transaction reads or writes, depending on the top bit of the command word.

A write sends a 7-bit register address and 16 bits of data to the codec register port. A read sends the address, then waits for the codec to return data. The returned data lands in the slot-2 receive register at bit 4. The command word, with its read bit cleared, is echoed into the slot-1 receive register. Busy and valid flags track the exchange for the host. Frame serialization is handled elsewhere.

The codec side uses two valid/ready channels. On the command channel, `cmd_valid` stays high and all command fields stay constant until a cycle in which `cmd_ready` is high. On the response channel, `rsp_ready` is high only while a read is waiting for its data, and `rsp_valid` has no effect in any other cycle. The host register port is plain. `host_sel` picks the register: 0 is the slot-1 transmit word, 1 is the slot-2 transmit word, 2 is the slot-1 receive word and 3 is the slot-2 receive word. `host_rdata` follows the selected register combinationally.

Top module: `codec_slot_ctrl`

## Requirements
- R1: After reset, `s1_tx_empty`, `s2_tx_empty` and `s12_tx_empty` are 1. Both busy flags, both valid flags and `cmd_valid` are 0, and all four registers read 0.
- R2: A host write with `host_sel`=1 stores the word in the slot-2 transmit register. It clears `s2_tx_empty` and `s12_tx_empty` from the next cycle on.
- R3: A host write with `host_sel`=0 while no transaction is outstanding does four things. It stores the word, clears `s1_tx_empty` and `s12_tx_empty`, and raises `cmd_valid` in the next cycle. The command carries `cmd_read` = bit 19 of the word, `cmd_addr` = bits 18:12, and `cmd_data` = bits 19:4 of the slot-2 transmit word held at that moment.
- R4: `cmd_valid` stays high, with `cmd_read`, `cmd_addr` and `cmd_data` unchanged, until a cycle with `cmd_ready` high. Each launch yields exactly one accepted command.
- R5: When a command is accepted, all three transmit-empty flags return to 1, unless a slot-2 write happens in the same cycle.
- R6: Launching a read sets `s1_rx_busy` and `s2_rx_busy` until the response arrives. A write launch leaves both busy flags at 0.
- R7: A response is taken in a cycle with both `rsp_valid` and `rsp_ready` high. It makes the slot-1 receive register the command word with bit 19 cleared, and the slot-2 receive register `rsp_data` shifted left by 4 with bits 3:0 zero. It clears both busy flags and sets both valid flags.
- R8: A host read with `host_sel`=2 clears `s1_rx_valid`, and one with `host_sel`=3 clears `s2_rx_valid`. Neither touches the other flag.
- R9: A slot-1 write while a transaction is outstanding is ignored. The stored word, the flags and the command output stay as they were, and no extra command is issued.
- R10: `rsp_valid` while no read is waiting is ignored. The receive registers and the valid flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_sel | input | 2 | Register select (0 s1 tx, 1 s2 tx, 2 s1 rx, 3 s2 rx) |
| host_wdata | input | 20 | Host write word |
| host_rdata | output | 20 | Selected register contents |
| cmd_valid | output | 1 | Codec command present |
| cmd_ready | input | 1 | Codec accepts command |
| cmd_read | output | 1 | 1 = register read, 0 = register write |
| cmd_addr | output | 7 | Codec register address |
| cmd_data | output | 16 | Codec register write data |
| rsp_valid | input | 1 | Codec read data present |
| rsp_ready | output | 1 | Controller waiting for read data |
| rsp_data | input | 16 | Codec read data |
| s1_tx_empty | output | 1 | Slot-1 transmit word consumed |
| s2_tx_empty | output | 1 | Slot-2 transmit word consumed |
| s12_tx_empty | output | 1 | Both transmit words consumed |
| s1_rx_busy | output | 1 | Slot-1 receive pending |
| s2_rx_busy | output | 1 | Slot-2 receive pending |
| s1_rx_valid | output | 1 | Slot-1 receive word unread |
| s2_rx_valid | output | 1 | Slot-2 receive word unread |

## Verification
The bench holds `cmd_ready` low across several cycles. A design that drops or re-issues the command under back-pressure would either lose the command or leave the scoreboard with an extra one. It also fires a second slot-1 write while a command is still pending. A design that accepts that write would overwrite the echo word or launch a duplicate command.

It sends responses both when a read is waiting and when none is. A design that does not gate `rsp_valid` with its waiting state would corrupt the receive registers. Receive registers are read one at a time. A design that ties the two valid flags together, or forgets to clear bit 19 of the echo, or misplaces the data shift, would show up in the values read back.

// File: rtl/codec_slot_pkg.sv
package codec_slot_pkg;
  typedef enum logic [1:0] {
    SEL_S1TX = 2'd0,
    SEL_S2TX = 2'd1,
    SEL_S1RX = 2'd2,
    SEL_S2RX = 2'd3
  } slot_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/slot_tx_bank.sv
module slot_tx_bank #(
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_take,
  input  logic              s2_take,
  input  logic              cmd_accept,
  input  logic [SLOT_W-1:0] wdata,
  output logic [SLOT_W-1:0] s1_word,
  output logic [SLOT_W-1:0] s2_word,
  output logic              s1_empty,
  output logic              s2_empty,
  output logic              s12_empty
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_word   <= '0;
      s2_word   <= '0;
      s1_empty  <= 1'b1;
      s2_empty  <= 1'b1;
      s12_empty <= 1'b1;
    end else begin
      if (cmd_accept) begin
        s1_empty  <= 1'b1;
        s2_empty  <= 1'b1;
        s12_empty <= 1'b1;
      end
      if (s1_take) begin
        s1_word   <= wdata;
        s1_empty  <= 1'b0;
        s12_empty <= 1'b0;
      end
      if (s2_take) begin
        s2_word   <= wdata;
        s2_empty  <= 1'b0;
        s12_empty <= 1'b0;
      end
    end
  end

  // R5
  tx_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && !s2_take |=> s1_empty && s2_empty && s12_empty);

  // R2
  s2_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_take |=> !s2_empty && !s12_empty);
endmodule

// File: rtl/slot_xfer_fsm.sv
module slot_xfer_fsm
  import codec_slot_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [SLOT_W-1:0] launch_word,
  input  logic [SLOT_W-1:0] s2_word,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_read,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  output logic              idle,
  output logic              cmd_accept,
  output logic              rsp_done
);
  localparam int RW_BIT = SLOT_W - 1;

  xfer_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd_read <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (launch) begin
          state    <= ST_ISSUE;
          cmd_read <= launch_word[RW_BIT];
          cmd_addr <= launch_word[RW_BIT-1 -: ADDR_W];
          cmd_data <= s2_word[SLOT_W-1 -: DATA_W];
        end
        ST_ISSUE: if (cmd_ready) state <= cmd_read ? ST_WAIT : ST_IDLE;
        ST_WAIT:  if (rsp_valid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid  = (state == ST_ISSUE);
  assign rsp_ready  = (state == ST_WAIT);
  assign idle       = (state == ST_IDLE);
  assign cmd_accept = cmd_valid && cmd_ready;
  assign rsp_done   = rsp_ready && rsp_valid;

  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_read)
      && $stable(cmd_addr) && $stable(cmd_data));

  // R7
  chan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rsp_ready));
endmodule

// File: rtl/slot_rx_bank.sv
module slot_rx_bank #(
  parameter int SLOT_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_read,
  input  logic              rsp_done,
  input  logic [SLOT_W-1:0] echo_word,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              clr1,
  input  logic              clr2,
  output logic [SLOT_W-1:0] s1_rx,
  output logic [SLOT_W-1:0] s2_rx,
  output logic              busy,
  output logic              s1_valid,
  output logic              s2_valid
);
  localparam int RW_BIT   = SLOT_W - 1;
  localparam int DATA_LSB = SLOT_W - DATA_W;
  localparam logic [SLOT_W-1:0] RW_MASK = ~(SLOT_W'(1) << RW_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_rx    <= '0;
      s2_rx    <= '0;
      busy     <= 1'b0;
      s1_valid <= 1'b0;
      s2_valid <= 1'b0;
    end else begin
      if (launch_read) busy <= 1'b1;
      if (rsp_done) begin
        busy     <= 1'b0;
        s1_rx    <= echo_word & RW_MASK;
        s2_rx    <= {rsp_data, {DATA_LSB{1'b0}}};
        s1_valid <= 1'b1;
        s2_valid <= 1'b1;
      end else begin
        if (clr1) s1_valid <= 1'b0;
        if (clr2) s2_valid <= 1'b0;
      end
    end
  end

  // R7
  rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> s1_valid && s2_valid && !busy && !s1_rx[RW_BIT]);

  // R6
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_read |=> busy);
endmodule

// File: rtl/codec_slot_ctrl.sv
module codec_slot_ctrl
  import codec_slot_pkg::*;
#(
  parameter int SLOT_W = 20,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic [SLOT_W-1:0] host_wdata,
  output logic [SLOT_W-1:0] host_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_read,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              s1_tx_empty,
  output logic              s2_tx_empty,
  output logic              s12_tx_empty,
  output logic              s1_rx_busy,
  output logic              s2_rx_busy,
  output logic              s1_rx_valid,
  output logic              s2_rx_valid
);
  localparam int RW_BIT = SLOT_W - 1;

  slot_sel_e         sel;
  logic              idle, cmd_accept, rsp_done, s1_take, s2_take, launch_read;
  logic              rx_busy;
  logic [SLOT_W-1:0] s1_word, s2_word, s1_rx, s2_rx;

  assign sel         = slot_sel_e'(host_sel);
  assign s1_take     = host_wr && (sel == SEL_S1TX) && idle;
  assign s2_take     = host_wr && (sel == SEL_S2TX);
  assign launch_read = s1_take && host_wdata[RW_BIT];

  slot_tx_bank #(.SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .s1_take(s1_take), .s2_take(s2_take),
    .cmd_accept(cmd_accept), .wdata(host_wdata), .s1_word(s1_word),
    .s2_word(s2_word), .s1_empty(s1_tx_empty), .s2_empty(s2_tx_empty),
    .s12_empty(s12_tx_empty)
  );

  slot_xfer_fsm #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .launch(s1_take), .launch_word(host_wdata),
    .s2_word(s2_word), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .idle(idle),
    .cmd_accept(cmd_accept), .rsp_done(rsp_done)
  );

  slot_rx_bank #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .launch_read(launch_read), .rsp_done(rsp_done),
    .echo_word(s1_word), .rsp_data(rsp_data),
    .clr1(host_rd && (sel == SEL_S1RX)), .clr2(host_rd && (sel == SEL_S2RX)),
    .s1_rx(s1_rx), .s2_rx(s2_rx), .busy(rx_busy),
    .s1_valid(s1_rx_valid), .s2_valid(s2_rx_valid)
  );

  assign s1_rx_busy = rx_busy;
  assign s2_rx_busy = rx_busy;

  always_comb begin
    unique case (sel)
      SEL_S1TX: host_rdata = s1_word;
      SEL_S2TX: host_rdata = s2_word;
      SEL_S1RX: host_rdata = s1_rx;
      default:  host_rdata = s2_rx;
    endcase
  end

  // R9
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && (sel == SEL_S1TX) && !idle |=> $stable(s1_word));

  // R10
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> $stable(s2_rx) && $stable(s1_rx));
endmodule

// File: tb/codec_slot_ctrl_test.sv
`timescale 1ns/1ps
module codec_slot_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [19:0] host_wdata = '0;
  logic [19:0] host_rdata;
  logic        cmd_valid, cmd_ready = 1'b0, cmd_read;
  logic [6:0]  cmd_addr;
  logic [15:0] cmd_data;
  logic        rsp_valid = 1'b0, rsp_ready;
  logic [15:0] rsp_data = '0;
  logic        s1e, s2e, s12e, s1b, s2b, s1v, s2v;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [19:0] s2_shadow = '0;
  logic [23:0] exp_q[$];

  always #2 clk = ~clk;

  codec_slot_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .s1_tx_empty(s1e),
    .s2_tx_empty(s2e), .s12_tx_empty(s12e), .s1_rx_busy(s1b),
    .s2_rx_busy(s2b), .s1_rx_valid(s1v), .s2_rx_valid(s2v)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [19:0] w);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = w;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // driver: slot-1 launch that pushes the expected command
  task automatic launch(input logic [19:0] w);
    exp_q.push_back({w[19], w[18:12], s2_shadow[19:4]});
    host_write(2'd0, w);
  endtask

  task automatic set_s2(input logic [19:0] w);
    s2_shadow = w;
    host_write(2'd1, w);
  endtask

  task automatic host_read(input logic [1:0] sel, output logic [19:0] r);
    @(negedge clk);
    host_rd = 1'b1; host_sel = sel;
    #1 r = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic respond(input logic [15:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  // monitor: compare each accepted command against the scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4 extra command actual=%h expected=none",
                 {cmd_read, cmd_addr, cmd_data});
      end else begin
        chk("R3 command fields", {8'd0, cmd_read, cmd_addr, cmd_data}, {8'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog expired actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 empty flags", {s1e, s2e, s12e}, 3'b111);
    chk("R1 busy/valid", {s1b, s2b, s1v, s2v, cmd_valid}, 5'b0);
    for (int i = 0; i < 4; i++) begin
      host_read(i[1:0], r);
      chk("R1 register zero", r, 20'h0);
    end

    // R2 slot-2 load
    set_s2(20'hABCD0);
    chk("R2 empty flags", {s1e, s2e, s12e}, 3'b100);
    host_read(2'd1, r);
    chk("R2 slot2 word", r, 20'hABCD0);

    // R3/R4 write command under back-pressure
    cmd_ready = 1'b0;
    launch(20'h15123);
    chk("R3 flags after launch", {s1e, s2e, s12e, cmd_valid}, 4'b0001);
    repeat (3) @(negedge clk);
    chk("R4 valid held", cmd_valid, 1'b1);
    // R9 slot-1 write while pending
    host_write(2'd0, 20'hFFFFF);
    host_read(2'd0, r);
    chk("R9 slot1 unchanged", r, 20'h15123);
    chk("R9 command unchanged", {cmd_valid, cmd_addr}, {1'b1, 7'h15});
    chk("R6 write leaves busy clear", {s1b, s2b}, 2'b00);
    @(negedge clk);
    cmd_ready = 1'b1;
    @(negedge clk);
    #1;
    chk("R5 empty flags restored", {s1e, s2e, s12e, cmd_valid}, 4'b1110);
    chk("R4 single command", exp_q.size(), 0);

    // R6/R7 read with response
    launch(20'hFC345);
    chk("R6 busy on read launch", {s1b, s2b}, 2'b11);
    @(negedge clk);
    chk("R7 waiting for data", {rsp_ready, s1v, s2v, s1b}, 4'b1001);
    respond(16'h5A3C);
    chk("R7 flags after response", {s1b, s2b, s1v, s2v, rsp_ready}, 5'b00110);
    // R8 reads clear each valid separately
    host_read(2'd2, r);
    chk("R7 echo word", r, 20'h7C345);
    chk("R8 slot1 valid cleared only", {s1v, s2v}, 2'b01);
    host_read(2'd3, r);
    chk("R7 data at bit 4", r, 20'h5A3C0);
    chk("R8 slot2 valid cleared", {s1v, s2v}, 2'b00);

    // R10 stray response
    respond(16'h1234);
    chk("R10 valid flags", {s1v, s2v, s1b}, 3'b000);
    host_read(2'd3, r);
    chk("R10 slot2 rx unchanged", r, 20'h5A3C0);

    // R3 boundary address with new slot-2 data
    set_s2(20'h00010);
    launch(20'h7F000);
    repeat (2) @(negedge clk);
    chk("R5 restored after 0x7F write", {s1e, s2e, s12e}, 3'b111);

    // R7 read at address 0 with delays and full-scale data
    cmd_ready = 1'b0;
    launch(20'h80ABC);
    repeat (2) @(negedge clk);
    chk("R4 held during read", {cmd_valid, cmd_read}, 2'b11);
    cmd_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 busy while waiting", {s1b, s2b, rsp_ready}, 3'b111);
    respond(16'hFFFF);
    host_read(2'd2, r);
    chk("R7 echo bit19 cleared", r, 20'h00ABC);
    host_read(2'd3, r);
    chk("R7 full-scale data", r, 20'hFFFF0);
    chk("R4 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule